// File: doc/BRIEF.md
# Split-Point Information Scorer

The block scores candidate split points for two-class training data and keeps the best one. For each candidate it receives a threshold value and the number of samples of each class that fall on one side of that threshold. From these it forms the class proportion p in fixed point and looks up an approximate information figure in a built-in table. The table holds the quadratic 4·p·(1−p), which stands in for the normalised binary entropy. A comparator then checks the figure against the best value seen so far in the session, and two registers hold the winning threshold and its figure.

A session opens with a one-cycle `start` pulse, which clears the stored best. While the block raises `cand_req`, the host presents candidates with `cand_valid` and flags the final one with `cand_last`. Three clock edges after the final candidate is accepted, the best registers hold the session result and `done` pulses for one cycle. The result appears on the outputs only while `oe` is high.

Top module: `ebe_top`

## Requirements
- R1: After reset, `cand_req` and `done` are low, and the stored best threshold and best figure are zero.
- R2: A `start` pulse opens a session. From the next cycle `cand_req` is high, and it stays high until the candidate flagged `cand_last` has been accepted.
- R3: The proportion index is floor(cnt_a·256 / (cnt_a+cnt_b)), saturated to 255. A candidate whose counts are both zero gets index 0.
- R4: The information figure for index i is min(255, floor(4·i·(256−i)/256)). Index 128 therefore gives 255, and index 0 gives 0.
- R5: `start` clears the stored best figure and best threshold to zero in the following cycle.
- R6: The best registers change only when a candidate's figure is strictly greater than the stored figure. On a tie the earlier threshold is kept, and within a session the stored figure never decreases.
- R7: `done` is high for exactly one cycle. It is high in the cycle in which the last candidate's result has been committed, which is three edges after that candidate was accepted.
- R8: When `done` is high, `cand_req` is low. A candidate presented while `cand_req` is low has no effect on the best registers.
- R9: When `oe` is low, `best_thr` and `best_info` read zero. When `oe` is high, they show the stored best.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a session and clears the stored best |
| cand_valid | input | 1 | Candidate present this cycle |
| cand_last | input | 1 | Marks the final candidate of the session |
| cand_thr | input | 8 | Threshold value of the candidate |
| cnt_a | input | 8 | Count of class A samples on the low side |
| cnt_b | input | 8 | Count of class B samples on the low side |
| oe | input | 1 | Output enable for the result |
| cand_req | output | 1 | High while the block accepts candidates |
| done | output | 1 | One-cycle pulse when the session result is ready |
| best_thr | output | 8 | Best threshold (zero unless `oe`) |
| best_info | output | 8 | Information figure of the best threshold (zero unless `oe`) |

## Verification
The assertions check the following on every cycle: the stored maximum clears after `start`, the figure never decreases inside a session, the threshold moves only together with a rise in the figure, `done` lasts a single cycle, the request line is low while `done` is high, and the outputs are gated by `oe`. Only the bench scenarios can show that the numbers are right. These scenarios cover the proportion and table arithmetic, the arg-max choice over a sequence, the tie rule, the zero-count and saturated-index corners, and a candidate ignored outside a session. A scoreboard predicts each session result from the requirement formulas.

// File: rtl/ebe_pkg.sv
package ebe_pkg;

    parameter int CNT_W  = 8;
    parameter int THR_W  = 8;
    parameter int IDX_W  = 8;
    parameter int INFO_W = 8;

    localparam int TBL_N   = 1 << IDX_W;
    localparam int NUM_W   = CNT_W + IDX_W;
    localparam int DEN_W   = CNT_W + 1;
    localparam int IDX_MAX = TBL_N - 1;
    localparam int INFO_MX = (1 << INFO_W) - 1;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic [THR_W-1:0] thr;
        logic [IDX_W-1:0] idx;
    } ratio_t;

    typedef struct packed {
        logic              valid;
        logic              last;
        logic [THR_W-1:0]  thr;
        logic [INFO_W-1:0] info;
    } score_t;

    // fixed-point proportion of class A, saturated to the table range
    function automatic logic [IDX_W-1:0] ratio_index(input logic [CNT_W-1:0] a,
                                                     input logic [CNT_W-1:0] b);
        logic [DEN_W-1:0] den;
        logic [NUM_W-1:0] num;
        logic [NUM_W-1:0] quo;
        den = DEN_W'(a) + DEN_W'(b);
        num = {a, {IDX_W{1'b0}}};
        if (den == '0) begin
            return '0;
        end
        quo = num / NUM_W'(den);
        if (quo > NUM_W'(IDX_MAX)) begin
            return IDX_W'(IDX_MAX);
        end
        return quo[IDX_W-1:0];
    endfunction

    // quadratic stand-in for normalised binary entropy: 4 p (1-p)
    function automatic logic [INFO_W-1:0] quad_info(input int i);
        int prod;
        prod = (4 * i * (TBL_N - i)) >>> IDX_W;
        if (prod > INFO_MX) begin
            prod = INFO_MX;
        end
        return INFO_W'(prod);
    endfunction

endpackage

// File: rtl/ebe_ratio.sv
module ebe_ratio
    import ebe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [THR_W-1:0] in_thr,
    input  logic [CNT_W-1:0] in_a,
    input  logic [CNT_W-1:0] in_b,
    output ratio_t           out_q
);

    ratio_t nxt;

    always_comb begin
        nxt.valid = in_valid & ~flush;
        nxt.last  = in_last & in_valid & ~flush;
        nxt.thr   = in_thr;
        nxt.idx   = ratio_index(in_a, in_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

endmodule

// File: rtl/ebe_lut.sv
module ebe_lut
    import ebe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  ratio_t in_q,
    output score_t out_q
);

    logic [INFO_W-1:0] table_w [TBL_N];

    for (genvar gi = 0; gi < TBL_N; gi++) begin : g_tbl
        assign table_w[gi] = quad_info(gi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_q.valid & ~flush;
            out_q.last  <= in_q.last & ~flush;
            out_q.thr   <= in_q.thr;
            out_q.info  <= table_w[in_q.idx];
        end
    end

endmodule

// File: rtl/ebe_track.sv
module ebe_track
    import ebe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  score_t            in_q,
    output logic [THR_W-1:0]  max_thr,
    output logic [INFO_W-1:0] max_info,
    output logic              fin
);

    logic better;

    assign better = in_q.valid && (in_q.info > max_info);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            max_thr  <= '0;
            max_info <= '0;
            fin      <= 1'b0;
        end else begin
            if (better) begin
                max_thr  <= in_q.thr;
                max_info <= in_q.info;
            end
            fin <= in_q.valid & in_q.last;
        end
    end

endmodule

// File: rtl/ebe_top.sv
module ebe_top
    import ebe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cand_valid,
    input  logic              cand_last,
    input  logic [THR_W-1:0]  cand_thr,
    input  logic [CNT_W-1:0]  cnt_a,
    input  logic [CNT_W-1:0]  cnt_b,
    input  logic              oe,
    output logic              cand_req,
    output logic              done,
    output logic [THR_W-1:0]  best_thr,
    output logic [INFO_W-1:0] best_info
);

    logic              active_q;
    logic              accept;
    ratio_t            s1_q;
    score_t            s2_q;
    logic [THR_W-1:0]  max_thr;
    logic [INFO_W-1:0] max_info;

    assign accept = active_q & cand_valid & ~start;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
        end else if (accept && cand_last) begin
            active_q <= 1'b0;
        end
    end

    ebe_ratio u_ratio (
        .clk      (clk),
        .rst      (rst),
        .flush    (start),
        .in_valid (accept),
        .in_last  (cand_last),
        .in_thr   (cand_thr),
        .in_a     (cnt_a),
        .in_b     (cnt_b),
        .out_q    (s1_q)
    );

    ebe_lut u_lut (
        .clk   (clk),
        .rst   (rst),
        .flush (start),
        .in_q  (s1_q),
        .out_q (s2_q)
    );

    ebe_track u_track (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .in_q     (s2_q),
        .max_thr  (max_thr),
        .max_info (max_info),
        .fin      (done)
    );

    assign cand_req  = active_q;
    assign best_thr  = oe ? max_thr  : '0;
    assign best_info = oe ? max_info : '0;

endmodule

// File: rtl/ebe_chk.sv
module ebe_chk
    import ebe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              oe,
    input logic              cand_req,
    input logic              done,
    input logic [THR_W-1:0]  best_thr,
    input logic [INFO_W-1:0] best_info,
    input logic [THR_W-1:0]  max_thr,
    input logic [INFO_W-1:0] max_info
);

    p_clear_on_start_r5: assert property (@(posedge clk) disable iff (rst)
        start |=> (max_info == '0 && max_thr == '0));

    p_no_decrease_r6: assert property (@(posedge clk) disable iff (rst)
        !start |=> (max_info >= $past(max_info)));

    p_thr_follows_info_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && $stable(max_info)) |-> $stable(max_thr));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_req_low_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !cand_req);

    p_oe_gates_r9: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (best_thr == '0 && best_info == '0));

endmodule

bind ebe_top ebe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .oe        (oe),
    .cand_req  (cand_req),
    .done      (done),
    .best_thr  (best_thr),
    .best_info (best_info),
    .max_thr   (max_thr),
    .max_info  (max_info)
);

// File: tb/ebe_top_bench.sv
`timescale 1ns/1ps
module ebe_top_bench;
    import ebe_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              cand_valid = 1'b0;
    logic              cand_last = 1'b0;
    logic [THR_W-1:0]  cand_thr = '0;
    logic [CNT_W-1:0]  cnt_a = '0;
    logic [CNT_W-1:0]  cnt_b = '0;
    logic              oe = 1'b1;
    logic              cand_req;
    logic              done;
    logic [THR_W-1:0]  best_thr;
    logic [INFO_W-1:0] best_info;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ref_info;
    int ref_thr;
    int exp_q[$];
    int sessions_seen = 0;

    always #2.5 clk = ~clk;

    ebe_top u_ebe_top (
        .clk(clk), .rst(rst), .start(start), .cand_valid(cand_valid),
        .cand_last(cand_last), .cand_thr(cand_thr), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .oe(oe), .cand_req(cand_req), .done(done), .best_thr(best_thr),
        .best_info(best_info)
    );

    function automatic int model_idx(int a, int b);
        int q;
        if (a + b == 0) return 0;
        q = (a * 256) / (a + b);
        return (q > 255) ? 255 : q;
    endfunction

    function automatic int model_info(int i);
        int v;
        v = (4 * i * (256 - i)) / 256;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic open_session();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ref_info = 0;
        ref_thr  = 0;
    endtask

    task automatic send(int thr, int a, int b, bit last, bit in_session);
        int f;
        cand_valid = 1'b1;
        cand_last  = last;
        cand_thr   = THR_W'(thr);
        cnt_a      = CNT_W'(a);
        cnt_b      = CNT_W'(b);
        @(negedge clk);
        cand_valid = 1'b0;
        cand_last  = 1'b0;
        if (in_session) begin
            f = model_info(model_idx(a, b));
            if (f > ref_info) begin   // R6 strict compare, tie keeps earlier
                ref_info = f;
                ref_thr  = thr;
            end
            if (last) exp_q.push_back(ref_thr * 256 + ref_info);
        end
    endtask

    // monitor: compares each session result when done pulses (R7, R4, R3, R6)
    always @(negedge clk) begin
        if (!rst && done) begin
            int e;
            sessions_seen++;
            check("R8 req low at done", int'(cand_req), 0);
            if (exp_q.size() == 0) begin
                check("R7 unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check("R6 best threshold", int'(best_thr), e / 256);
                check("R4 best information", int'(best_info), e % 256);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        check("R7 done seen", int'(done), 1);
        @(negedge clk);
        check("R7 done one cycle", int'(done), 0);
    endtask

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 cand_req", int'(cand_req), 0);
        check("R1 done", int'(done), 0);
        check("R1 best_thr", int'(best_thr), 0);
        check("R1 best_info", int'(best_info), 0);

        // R2 session opens
        open_session();
        check("R2 cand_req high", int'(cand_req), 1);
        send(10, 10, 90, 0, 1);
        send(20, 50, 50, 0, 1);   // index 128 -> 255
        send(30, 60, 40, 1, 1);
        check("R2 cand_req drops after last", int'(cand_req), 0);
        wait_done();

        // R6 tie: both give index 128, earlier threshold kept
        open_session();
        check("R5 cleared info", int'(best_info), 0);
        check("R5 cleared thr", int'(best_thr), 0);
        send(5, 1, 1, 0, 1);
        cand_valid = 1'b0; @(negedge clk);   // gap
        send(6, 100, 100, 1, 1);
        wait_done();

        // R3 corners: zero counts, saturated index, zero class A
        open_session();
        send(40, 0, 0, 0, 1);
        send(41, 5, 0, 0, 1);
        send(42, 0, 9, 1, 1);
        wait_done();
        check("R3 saturated index figure", model_info(model_idx(5, 0)), 3);

        // R4 sweep over many patterns
        s = 7;
        open_session();
        for (int k = 0; k < 40; k++) begin
            s = (s * 37 + 11) % 251;
            send(k + 1, s, (s * 13 + 5) % 256, k == 39, 1);
        end
        wait_done();

        // R8 ignored candidate while req low
        send(99, 128, 128, 1, 0);
        repeat (4) @(negedge clk);
        check("R8 ignored thr", int'(best_thr), ref_thr);
        check("R8 ignored info", int'(best_info), ref_info);
        check("R8 no done", sessions_seen, 4);

        // R9 output enable gating
        oe = 1'b0;
        @(negedge clk);
        check("R9 thr gated", int'(best_thr), 0);
        check("R9 info gated", int'(best_info), 0);
        oe = 1'b1;
        @(negedge clk);
        check("R9 thr shown", int'(best_thr), ref_thr);

        check("R7 sessions", sessions_seen, 4);
        check("R6 queue drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule